// File: doc/BRIEF.md
# Gain Update Controller with Zero-Cross Deferral

This block decides which gain, in dB, a microphone preamplifier stage actually applies. It takes a 6-bit gain code that a control register has already latched and converts it to a dB value through a non-linear map. That map has a unity code, a linear offset range and a saturated top range. The block then applies the value either at once or at a quiet point of the audio, which is a zero crossing of the incoming sample stream.

A change is held pending while zero-cross mode is on. If no crossing arrives, a bounded timer releases the change. A new code that arrives during the wait restarts the timer. A unity-gain override pin forces 0 dB at once, whatever the code is. The code may change while the pin is high without the new value being applied. When the pin drops, the return to the programmed gain is treated as an ordinary gain change. A one-cycle pulse marks every change of the applied gain. The block works in one clock domain and holds decision logic only.

Top module: `gain_zc_ctrl`

## Requirements
- R1: The applied gain for a code N (applied with zero-cross mode off) is 0 dB for N = 0, 9 + N dB for N = 1 to 56, and 65 dB for N = 57 to 63.
- R2: While `unity_force` is high, `gain_db` reads 0 from the clock edge after the pin is first seen high.
- R3: Code changes made while `unity_force` is high do not alter `gain_db`. After the pin goes low, the gain for the latest code is applied.
- R4: With `zc_en` high, a pending change is applied on the clock edge where a valid sample's sign (two's complement MSB) differs from that of the previous valid sample. Samples with `smp_valid` low are ignored.
- R5: With `zc_en` high and no crossing, a pending change is applied after `TIMEOUT_CYC` cycles, counted from the last change of the requested gain. The change is applied no later than `TIMEOUT_CYC` + 2 edges after the request. A newer code restarts the count.
- R6: With `zc_en` low, a new code's gain appears on `gain_db` one clock edge after the code is presented.
- R7: A valid sample equal to exactly zero counts as a crossing.
- R8: `gain_upd` is high for exactly the one cycle in which `gain_db` holds a value different from the previous cycle.
- R9: Releasing `unity_force` while `zc_en` is high leaves 0 dB applied until a crossing or the timeout.
- R10: After reset, `gain_db` is 0 and `gain_upd` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gain_code | input | CODE_W | Latched gain code |
| unity_force | input | 1 | Forces 0 dB; defers programmed gain while high |
| zc_en | input | 1 | Enables zero-cross deferral |
| smp_valid | input | 1 | Qualifies smp_data |
| smp_data | input | SMP_W | Signed audio sample |
| gain_db | output | DB_W | Gain currently applied, in dB |
| gain_upd | output | 1 | One-cycle pulse when gain_db changes |

## Verification
Some properties are checked on every cycle. These are the legal range of the applied gain, the 0 dB override, the one-cycle latency with deferral off, the pairing of the update pulse with a change of value, and the stability of the gain while deferral waits with no valid sample and no expiry. The bench scenarios cover the rest. They sweep every code through the map, show that an override hides register rewrites, and place a crossing between samples of the same and opposite signs and on an exact zero. They also show the timeout releasing a change and a second code restarting the timer.

// File: rtl/gzc_pkg.sv
// Package: shared widths and code-map constants for the gain update controller.
// Assumes: codes are unsigned, gains are whole dB values below 128.
package gzc_pkg;
    localparam int DB_W      = 7;
    localparam int GAIN_OFS  = 9;
    localparam int CODE_SAT  = 56;
    localparam int GAIN_MAX  = 65;
endpackage

// File: rtl/gzc_gain_map.sv
// Module: converts a gain code into dB (unity, offset range, saturation).
// Assumes: CODE_W wide enough to reach CODE_SAT; purely combinational.
module gzc_gain_map #(
    parameter int CODE_W = 6
) (
    input  logic [CODE_W-1:0]        code,
    output logic [gzc_pkg::DB_W-1:0] db
);
    import gzc_pkg::*;

    // Piecewise map of code to dB.
    always_comb begin
        if (code == '0) begin
            db = '0;
        end else if (int'(code) > CODE_SAT) begin
            db = DB_W'(GAIN_MAX);
        end else begin
            db = DB_W'(int'(code) + GAIN_OFS);
        end
    end
endmodule

// File: rtl/gzc_zero_detect.sv
// Module: flags a zero crossing on the valid sample presented this cycle.
// Assumes: two's complement samples; the first valid sample after reset
// crosses only if it is exactly zero.
module gzc_zero_detect #(
    parameter int SMP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_valid,
    input  logic [SMP_W-1:0] smp_data,
    output logic             zc_hit
);
    localparam int MSB = SMP_W - 1;

    logic prev_neg;
    logic have_prev;

    // Remember the sign of the last valid sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_neg  <= 1'b0;
            have_prev <= 1'b0;
        end else if (smp_valid) begin
            prev_neg  <= smp_data[MSB];
            have_prev <= 1'b1;
        end
    end

    // Crossing: exact zero, or a sign flip against the last valid sample.
    always_comb begin
        zc_hit = smp_valid &&
                 ((smp_data == '0) || (have_prev && (smp_data[MSB] != prev_neg)));
    end
endmodule

// File: rtl/gzc_pend_timer.sv
// Module: counts cycles a change has been pending and signals expiry.
// Assumes: retrigger is high for one cycle when the requested gain moves.
module gzc_pend_timer #(
    parameter int TIMEOUT_CYC = 1600000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    input  logic retrigger,
    output logic expire
);
    localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYC - 1);

    logic [CNT_W-1:0] cnt;

    // Advance while pending, restart on a new request or when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!pending || retrigger) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Expiry once the full window has elapsed on an unchanged request.
    always_comb begin
        expire = pending && !retrigger && (cnt == LAST);
    end
endmodule

// File: rtl/gain_zc_ctrl.sv
// Module: top of the gain update controller. Decides the applied gain from
// the code, the unity override and the zero-cross/timeout deferral rule.
// Assumes: all inputs synchronous to clk.
module gain_zc_ctrl #(
    parameter int CODE_W      = 6,
    parameter int SMP_W       = 16,
    parameter int TIMEOUT_CYC = 1600000
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [CODE_W-1:0]           gain_code,
    input  logic                        unity_force,
    input  logic                        zc_en,
    input  logic                        smp_valid,
    input  logic [SMP_W-1:0]            smp_data,
    output logic [gzc_pkg::DB_W-1:0]    gain_db,
    output logic                        gain_upd
);
    import gzc_pkg::*;

    logic [DB_W-1:0] want_db;
    logic [DB_W-1:0] want_q;
    logic [DB_W-1:0] applied;
    logic [DB_W-1:0] next_db;
    logic            zc_hit;
    logic            tmr_expire;
    logic            pending;
    logic            retrig;
    logic            upd_q;

    gzc_gain_map #(.CODE_W(CODE_W)) u_map (
        .code (gain_code),
        .db   (want_db)
    );

    gzc_zero_detect #(.SMP_W(SMP_W)) u_zc (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .zc_hit    (zc_hit)
    );

    gzc_pend_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .pending   (pending),
        .retrigger (retrig),
        .expire    (tmr_expire)
    );

    // Pending state and request-change detection.
    always_comb begin
        retrig  = (want_db != want_q);
        pending = !unity_force && zc_en && (want_db != applied);
    end

    // Next applied gain: override, immediate, or deferred release.
    always_comb begin
        if (unity_force) begin
            next_db = '0;
        end else if ((want_db != applied) && (!zc_en || zc_hit || tmr_expire)) begin
            next_db = want_db;
        end else begin
            next_db = applied;
        end
    end

    // Register the applied gain, the last request and the update pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            applied <= '0;
            want_q  <= '0;
            upd_q   <= 1'b0;
        end else begin
            applied <= next_db;
            want_q  <= want_db;
            upd_q   <= (next_db != applied);
        end
    end

    assign gain_db  = applied;
    assign gain_upd = upd_q;
endmodule

// File: rtl/gain_zc_ctrl_chk.sv
// Module: property checker for gain_zc_ctrl, attached through bind.
module gain_zc_ctrl_chk #(
    parameter int DB_W = 7
) (
    input logic            clk,
    input logic            rst_n,
    input logic            unity_force,
    input logic            zc_en,
    input logic            smp_valid,
    input logic            tmr_expire,
    input logic [DB_W-1:0] want_db,
    input logic [DB_W-1:0] gain_db,
    input logic            gain_upd
);
    AST_GAIN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_db == '0) || ((gain_db >= 7'd10) && (gain_db <= 7'd65))); // R1
    AST_UNITY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        unity_force |=> (gain_db == '0)); // R2
    AST_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!unity_force && !zc_en) |=> (gain_db == $past(want_db))); // R6
    AST_ZC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!unity_force && zc_en && !smp_valid && !tmr_expire) |=> $stable(gain_db)); // R4
    AST_UPD_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
        gain_upd |-> (gain_db != $past(gain_db))); // R8
    AST_NO_UPD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !gain_upd |-> $stable(gain_db)); // R8
endmodule

bind gain_zc_ctrl gain_zc_ctrl_chk #(.DB_W(gzc_pkg::DB_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .unity_force (unity_force),
    .zc_en       (zc_en),
    .smp_valid   (smp_valid),
    .tmr_expire  (tmr_expire),
    .want_db     (want_db),
    .gain_db     (gain_db),
    .gain_upd    (gain_upd)
);

// File: tb/gain_zc_ctrl_test.sv
module gain_zc_ctrl_test;
    localparam int TO = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] gain_code = '0;
    logic       unity_force = 1'b0;
    logic       zc_en = 1'b0;
    logic       smp_valid = 1'b0;
    logic [7:0] smp_data = '0;
    logic [6:0] gain_db;
    logic       gain_upd;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    gain_zc_ctrl #(.CODE_W(6), .SMP_W(8), .TIMEOUT_CYC(TO)) uut (
        .clk(clk), .rst_n(rst_n), .gain_code(gain_code),
        .unity_force(unity_force), .zc_en(zc_en), .smp_valid(smp_valid),
        .smp_data(smp_data), .gain_db(gain_db), .gain_upd(gain_upd)
    );

    function automatic int exp_db(int c);
        if (c == 0) return 0;
        if (c > 56) return 65;
        return c + 9;
    endfunction

    task automatic chk(string req, int got, int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s got=%0d exp=%0d", req, got, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(logic [7:0] s);
        smp_valid = 1'b1;
        smp_data  = s;
        step(1);
        smp_valid = 1'b0;
        smp_data  = 8'h80;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int prev;
        step(3);
        rst_n = 1'b1;
        step(1);
        chk("R10 gain", gain_db, 0);
        chk("R10 upd", gain_upd, 0);

        // R1/R6/R8: sweep all codes with deferral off
        prev = 0;
        for (int c = 0; c < 64; c++) begin
            gain_code = 6'(c);
            step(1);
            chk("R1 map", gain_db, exp_db(c));
            chk("R8 upd", gain_upd, int'(exp_db(c) != prev));
            prev = exp_db(c);
        end
        step(1);
        chk("R8 upd idle", gain_upd, 0);

        // R2/R3: override and hidden rewrite
        unity_force = 1'b1;
        step(1);
        chk("R2 unity", gain_db, 0);
        gain_code = 6'd20;
        step(3);
        chk("R3 hidden", gain_db, 0);
        unity_force = 1'b0;
        step(1);
        chk("R3 release", gain_db, 29);

        // R4: crossing release
        zc_en = 1'b1;
        send(8'd5);
        gain_code = 6'd30;
        step(10);
        chk("R4 wait", gain_db, 29);
        smp_data = 8'hF0;
        step(2);
        chk("R4 invalid ignored", gain_db, 29);
        send(8'd7);
        chk("R4 same sign", gain_db, 29);
        send(8'hFD);
        chk("R4 cross", gain_db, 39);
        chk("R8 upd zc", gain_upd, 1);

        // R7: exact zero
        gain_code = 6'd5;
        step(2);
        chk("R7 wait", gain_db, 39);
        send(8'd0);
        chk("R7 zero", gain_db, 14);

        // R5: timeout
        gain_code = 6'd40;
        step(30);
        chk("R5 before", gain_db, 14);
        step(15);
        chk("R5 expired", gain_db, 49);

        // R5: restart on newer code
        gain_code = 6'd41;
        step(30);
        chk("R5 pending", gain_db, 49);
        gain_code = 6'd42;
        step(30);
        chk("R5 restart", gain_db, 49);
        step(15);
        chk("R5 restart expired", gain_db, 51);

        // R9: release under deferral
        unity_force = 1'b1;
        step(1);
        chk("R2 unity zc", gain_db, 0);
        unity_force = 1'b0;
        step(5);
        chk("R9 held", gain_db, 0);
        send(8'd4);
        chk("R9 no cross", gain_db, 0);
        send(8'hFC);
        chk("R9 cross", gain_db, 51);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule